// File: doc/BRIEF.md
# Loop Predicate Mask Generator

This block turns one loop-control instruction into a predicate mask. It decodes a 32-bit instruction word, names the two scalar source registers for the register-file read port, and takes back the two 64-bit operand values. From these it works out how many leading vector elements still fall inside the loop, and sets one predicate bit for each such element. The predicate has one bit per byte of the vector, so an element of 2, 4 or 8 bytes owns a group of bits, and only the lowest bit of each group can be set.

The element count is the operand difference, clamped to the vector length. The clamp comes first, so a loop that spans the whole 64-bit range cannot wrap to zero. The inclusive form adds one. A signed or unsigned compare of the two operands forces the count to zero when the loop has ended. Four condition flags that summarise the result leave together with the predicate and the destination predicate index, one clock after the input, marked by a one-cycle valid pulse.

The vector length is a parameter. It defaults to 256 bits, which gives a 32-bit predicate.

Top module: `loop_pred_gen`

## Requirements
- R1: An input is accepted only when bits 31:24 of the word equal 00100101, bit 21 is 1, bits 15:13 are 000 and bit 10 is 1. The fields are: element size in bits 23:22, second source register in bits 20:16, 64-bit flag in bit 12, unsigned flag in bit 11, first source register in bits 9:5, inclusive flag in bit 4 and destination predicate in bits 3:0. A word that does not match produces no output pulse and leaves the registered outputs unchanged.
- R2: When bit 12 is 0, only the low 32 bits of each operand are used. They are zero-extended when bit 11 is 1 and sign-extended when it is 0.
- R3: The element count is the 64-bit unsigned difference (second minus first), clamped to the vector length in bytes. A full-range difference therefore yields a full predicate.
- R4: When bit 4 is 1, the compare is less-or-equal and the clamped count is increased by one. Equal operands then give exactly one element.
- R5: The count is zero unless first < second (first <= second in the inclusive form). The compare is signed when bit 11 is 0 and unsigned when it is 1.
- R6: Element size code 0, 1, 2 or 3 selects 1, 2, 4 or 8-byte elements. Predicate bit k*2^code is set for each element k below the count, the count being limited to the elements that fit. All other bits are 0.
- R7: N equals predicate bit 0. Z is 1 when no predicate bit is set. C is 1 when the bit of the last element (index PRED_BITS - 2^code) is clear. V is always 0.
- R8: The predicate, flags and destination index are registered one clock after an accepted input, and out_valid is high for exactly that one cycle. After reset, out_valid and the predicate are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are valid |
| in_instr | input | 32 | Instruction word |
| src_a_data | input | 64 | Value of the first source register |
| src_b_data | input | 64 | Value of the second source register |
| src_a_sel | output | 5 | First source register index, decoded |
| src_b_sel | output | 5 | Second source register index, decoded |
| in_hit | output | 1 | Instruction word matches the accepted pattern |
| out_valid | output | 1 | One-cycle result pulse |
| out_pred | output | VL_BITS/8 | Predicate mask |
| out_dst | output | 4 | Destination predicate index |
| out_n | output | 1 | First element active |
| out_z | output | 1 | No element active |
| out_c | output | 1 | Last element inactive |
| out_v | output | 1 | Always 0 |

## Verification
The hardest cases to reach are those where the raw 64-bit difference is huge: an operand pair spanning the whole unsigned range, or a signed pair whose unsigned view looks reversed. Uniform random operands almost never give a small, non-zero, partly clamped count either. The stimulus therefore mixes directed extremes (0 to all-ones, -1 to 1, 32-bit values with junk in the upper half) with random pairs in which the second operand is the first plus a small signed offset. This covers every element size, both compare kinds and both operand widths.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE = 2'd0,
      ESZ_HALF = 2'd1,
      ESZ_WORD = 2'd2,
      ESZ_DBL  = 2'd3
   } esz_e;

   typedef struct packed {
      esz_e       esz;
      logic [4:0] rb;
      logic       wide;
      logic       uns;
      logic [4:0] ra;
      logic       incl;
      logic [3:0] pd;
   } lpg_ctl_t;

   localparam logic [7:0] LPG_MAJOR = 8'b0010_0101;

endpackage

// File: rtl/lpg_decode.sv
module lpg_decode
   import lpg_pkg::*;
(
   input  logic [31:0] instr,
   output lpg_ctl_t    ctl,
   output logic        hit
);

   always_comb begin
      hit = (instr[31:24] == LPG_MAJOR) && instr[21] &&
            (instr[15:13] == 3'b000) && instr[10];
      ctl.esz  = esz_e'(instr[23:22]);
      ctl.rb   = instr[20:16];
      ctl.wide = instr[12];
      ctl.uns  = instr[11];
      ctl.ra   = instr[9:5];
      ctl.incl = instr[4];
      ctl.pd   = instr[3:0];
   end

endmodule

// File: rtl/lpg_count.sv
module lpg_count #(
   parameter int VL_BYTES = 32,
   parameter int CNT_W    = $clog2(VL_BYTES + 2),
   parameter int BIT_W    = CNT_W + 3
) (
   input  logic [63:0]      op_a,
   input  logic [63:0]      op_b,
   input  logic             wide,
   input  logic             uns,
   input  logic             incl,
   input  logic [1:0]       esz,
   output logic [BIT_W-1:0] bit_cnt
);

   localparam logic [63:0]      VLB64  = 64'(VL_BYTES);
   localparam logic [BIT_W-1:0] PBITS  = BIT_W'(VL_BYTES);

   logic [63:0]      ext_a, ext_b, diff;
   logic [CNT_W-1:0] clamped, elems;
   logic [BIT_W-1:0] scaled;
   logic             lt_u, lt_s, same, go;

   always_comb begin
      if (wide) begin
         ext_a = op_a;
         ext_b = op_b;
      end else if (uns) begin
         ext_a = {32'b0, op_a[31:0]};
         ext_b = {32'b0, op_b[31:0]};
      end else begin
         ext_a = {{32{op_a[31]}}, op_a[31:0]};
         ext_b = {{32{op_b[31]}}, op_b[31:0]};
      end
   end

   always_comb begin
      diff    = ext_b - ext_a;
      clamped = (diff > VLB64) ? CNT_W'(VL_BYTES) : diff[CNT_W-1:0];
      lt_u    = ext_a < ext_b;
      lt_s    = $signed(ext_a) < $signed(ext_b);
      same    = ext_a == ext_b;
      go      = (uns ? lt_u : lt_s) | (incl & same);
      elems   = go ? (clamped + CNT_W'(incl)) : '0;
      scaled  = BIT_W'(elems) << esz;
      bit_cnt = (scaled > PBITS) ? PBITS : scaled;
   end

endmodule

// File: rtl/lpg_mask.sv
module lpg_mask #(
   parameter int PRED_BITS = 32,
   parameter int BIT_W     = 9
) (
   input  logic [BIT_W-1:0]     bit_cnt,
   input  logic [1:0]           esz,
   output logic [PRED_BITS-1:0] pred,
   output logic                 fl_n,
   output logic                 fl_z,
   output logic                 fl_c,
   output logic                 fl_v
);

   logic [PRED_BITS-1:0] therm, grid;

   for (genvar i = 0; i < PRED_BITS; i++) begin : g_bit
      assign therm[i] = BIT_W'(i) < bit_cnt;
      always_comb begin
         case (esz)
            2'd0:    grid[i] = 1'b1;
            2'd1:    grid[i] = (i % 2) == 0;
            2'd2:    grid[i] = (i % 4) == 0;
            default: grid[i] = (i % 8) == 0;
         endcase
      end
   end

   assign pred = therm & grid;

   always_comb begin
      fl_n = pred[0];
      fl_z = ~|pred;
      case (esz)
         2'd0:    fl_c = ~pred[PRED_BITS-1];
         2'd1:    fl_c = ~pred[PRED_BITS-2];
         2'd2:    fl_c = ~pred[PRED_BITS-4];
         default: fl_c = ~pred[PRED_BITS-8];
      endcase
      fl_v = 1'b0;
   end

endmodule

// File: rtl/loop_pred_gen.sv
module loop_pred_gen
   import lpg_pkg::*;
#(
   parameter int VL_BITS   = 256,
   parameter int PRED_BITS = VL_BITS / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [31:0]          in_instr,
   input  logic [63:0]          src_a_data,
   input  logic [63:0]          src_b_data,
   output logic [4:0]           src_a_sel,
   output logic [4:0]           src_b_sel,
   output logic                 in_hit,
   output logic                 out_valid,
   output logic [PRED_BITS-1:0] out_pred,
   output logic [3:0]           out_dst,
   output logic                 out_n,
   output logic                 out_z,
   output logic                 out_c,
   output logic                 out_v
);

   localparam int VL_BYTES = VL_BITS / 8;
   localparam int CNT_W    = $clog2(VL_BYTES + 2);
   localparam int BIT_W    = CNT_W + 3;

   if (VL_BITS < 128 || VL_BITS > 2048 || (VL_BITS % 128) != 0) begin : g_bad_vl
      $error("VL_BITS must be a multiple of 128 in 128..2048");
   end
   if (PRED_BITS != VL_BYTES) begin : g_bad_pb
      $error("PRED_BITS must equal VL_BITS/8");
   end

   lpg_ctl_t             ctl;
   logic [BIT_W-1:0]     bit_cnt;
   logic [PRED_BITS-1:0] pred_c;
   logic                 n_c, z_c, c_c, v_c;

   lpg_decode u_dec (
      .instr (in_instr),
      .ctl   (ctl),
      .hit   (in_hit)
   );

   assign src_a_sel = ctl.ra;
   assign src_b_sel = ctl.rb;

   lpg_count #(.VL_BYTES(VL_BYTES), .CNT_W(CNT_W), .BIT_W(BIT_W)) u_cnt (
      .op_a    (src_a_data),
      .op_b    (src_b_data),
      .wide    (ctl.wide),
      .uns     (ctl.uns),
      .incl    (ctl.incl),
      .esz     (ctl.esz),
      .bit_cnt (bit_cnt)
   );

   lpg_mask #(.PRED_BITS(PRED_BITS), .BIT_W(BIT_W)) u_msk (
      .bit_cnt (bit_cnt),
      .esz     (ctl.esz),
      .pred    (pred_c),
      .fl_n    (n_c),
      .fl_z    (z_c),
      .fl_c    (c_c),
      .fl_v    (v_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pred  <= '0;
         out_dst   <= '0;
         out_n     <= 1'b0;
         out_z     <= 1'b0;
         out_c     <= 1'b0;
         out_v     <= 1'b0;
      end else begin
         out_valid <= in_valid & in_hit;
         if (in_valid && in_hit) begin
            out_pred <= pred_c;
            out_dst  <= ctl.pd;
            out_n    <= n_c;
            out_z    <= z_c;
            out_c    <= c_c;
            out_v    <= v_c;
         end
      end
   end

endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
   parameter int PRED_BITS = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_hit,
   input logic [1:0]           in_esz,
   input logic                 out_valid,
   input logic [PRED_BITS-1:0] out_pred,
   input logic                 out_n,
   input logic                 out_z
);

   function automatic logic [PRED_BITS-1:0] grid_of(logic [1:0] e);
      logic [PRED_BITS-1:0] g;
      for (int i = 0; i < PRED_BITS; i++) g[i] = (i % (1 << e)) == 0;
      return g;
   endfunction

   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_hit) |=> out_valid);

   a_r1_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_hit) |=> !out_valid);

   a_r6_grid_only: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_hit) |=> ((out_pred & ~grid_of($past(in_esz))) == '0));

   a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_z == (out_pred == '0)));

   a_r7_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_n == out_pred[0]));

endmodule

bind loop_pred_gen lpg_checker #(.PRED_BITS(PRED_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_hit    (in_hit),
   .in_esz    (in_instr[23:22]),
   .out_valid (out_valid),
   .out_pred  (out_pred),
   .out_n     (out_n),
   .out_z     (out_z)
);

// File: tb/loop_pred_gen_tb.sv
`timescale 1ns/1ps
module loop_pred_gen_tb;

   localparam int PB = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [31:0]   in_instr = '0;
   logic [63:0]   a_d = '0, b_d = '0;
   logic [4:0]    a_sel, b_sel;
   logic          hit, o_valid, o_n, o_z, o_c, o_v;
   logic [PB-1:0] o_pred;
   logic [3:0]    o_dst;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   loop_pred_gen #(.VL_BITS(256)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .src_a_data(a_d), .src_b_data(b_d), .src_a_sel(a_sel), .src_b_sel(b_sel),
      .in_hit(hit), .out_valid(o_valid), .out_pred(o_pred), .out_dst(o_dst),
      .out_n(o_n), .out_z(o_z), .out_c(o_c), .out_v(o_v)
   );

   function automatic logic [31:0] mk(logic [1:0] esz, logic [4:0] rb, logic wide,
                                      logic uns, logic [4:0] ra, logic incl, logic [3:0] pd);
      return {8'b00100101, esz, 1'b1, rb, 3'b000, wide, uns, 1'b1, ra, incl, pd};
   endfunction

   function automatic logic [PB-1:0] ref_pred(logic [31:0] ins, logic [63:0] a, logic [63:0] b);
      logic signed [65:0] xa, xb, n, es;
      logic [PB-1:0] r = '0;
      logic ok;
      int nel;
      if (ins[12]) begin
         xa = ins[11] ? {2'b00, a} : {{2{a[63]}}, a};
         xb = ins[11] ? {2'b00, b} : {{2{b[63]}}, b};
      end else begin
         xa = ins[11] ? {34'b0, a[31:0]} : {{34{a[31]}}, a[31:0]};
         xb = ins[11] ? {34'b0, b[31:0]} : {{34{b[31]}}, b[31:0]};
      end
      ok  = ins[4] ? (xa <= xb) : (xa < xb);
      n   = ok ? (xb - xa + (ins[4] ? 66'sd1 : 66'sd0)) : 66'sd0;
      nel = PB >> ins[23:22];
      for (int e = 0; e < nel; e++) begin
         es = e;
         if (n > es) r[e << ins[23:22]] = 1'b1;
      end
      return r;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(string tag, logic [31:0] ins, logic [63:0] a, logic [63:0] b);
      logic [PB-1:0] e;
      int lastb;
      @(negedge clk);
      in_valid = 1'b1; in_instr = ins; a_d = a; b_d = b;
      @(negedge clk);
      in_valid = 1'b0;
      e = ref_pred(ins, a, b);
      lastb = PB - (1 << ins[23:22]);
      chk({tag, " R8 valid"}, 64'(o_valid), 64'd1);
      chk({tag, " pred"}, 64'(o_pred), 64'(e));
      chk({tag, " R7 flags NZCV"}, {60'd0, o_n, o_z, o_c, o_v},
          {60'd0, e[0], e == '0, ~e[lastb], 1'b0});
      chk({tag, " R8 dst"}, 64'(o_dst), 64'(ins[3:0]));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [PB-1:0] held;
      logic [31:0]   ins;
      logic [63:0]   ra, rb;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      chk("R8 reset valid", 64'(o_valid), 64'd0);
      chk("R8 reset pred", 64'(o_pred), 64'd0);
      rst_n = 1'b1;

      // R1 field extraction for the read port
      @(negedge clk);
      in_instr = mk(2'd1, 5'd17, 1'b0, 1'b1, 5'd9, 1'b0, 4'd6);
      #0.1;
      chk("R1 sel a", 64'(a_sel), 64'd9);
      chk("R1 sel b", 64'(b_sel), 64'd17);
      chk("R1 hit", 64'(hit), 64'd1);

      // R3 full unsigned range, inclusive
      run("R3 full range", mk(2'd0, 5'd1, 1'b1, 1'b1, 5'd2, 1'b1, 4'd3), 64'd0, '1);
      chk("R3 full pred", 64'(o_pred), 64'hFFFF_FFFF);
      // R5 signed vs unsigned
      run("R5 signed -1..1", mk(2'd0, 5'd1, 1'b1, 1'b0, 5'd2, 1'b0, 4'd1), '1, 64'd1);
      chk("R5 signed pred", 64'(o_pred), 64'h3);
      run("R5 unsigned -1..1", mk(2'd0, 5'd1, 1'b1, 1'b1, 5'd2, 1'b0, 4'd2), '1, 64'd1);
      chk("R5 unsigned pred", 64'(o_pred), 64'h0);
      // R2 32-bit operands with junk upper halves
      run("R2 sext32", mk(2'd0, 5'd1, 1'b0, 1'b0, 5'd2, 1'b0, 4'd4),
          64'h0000_0001_8000_0000, 64'hFFFF_FFFF_8000_0003);
      chk("R2 sext pred", 64'(o_pred), 64'h7);
      run("R2 zext32", mk(2'd0, 5'd1, 1'b0, 1'b1, 5'd2, 1'b0, 4'd5),
          64'hFFFF_0000_7FFF_FFFF, 64'h0000_1234_8000_0001);
      chk("R2 zext pred", 64'(o_pred), 64'h3);
      // R4 equality
      run("R4 incl equal", mk(2'd2, 5'd1, 1'b1, 1'b0, 5'd2, 1'b1, 4'd7), 64'd5, 64'd5);
      chk("R4 incl pred", 64'(o_pred), 64'h1);
      run("R4 excl equal", mk(2'd2, 5'd1, 1'b1, 1'b0, 5'd2, 1'b0, 4'd8), 64'd5, 64'd5);
      chk("R7 empty Z C", {62'd0, o_z, o_c}, 64'd3);
      // R6 element scaling and clamp
      run("R6 dbl 2", mk(2'd3, 5'd1, 1'b1, 1'b1, 5'd2, 1'b0, 4'd9), 64'd10, 64'd12);
      chk("R6 dbl 2 pred", 64'(o_pred), 64'h101);
      run("R6 dbl clamp", mk(2'd3, 5'd1, 1'b1, 1'b1, 5'd2, 1'b0, 4'd10), 64'd0, 64'd10);
      chk("R6 dbl clamp pred", 64'(o_pred), 64'h0101_0101);
      chk("R7 full C clear", 64'(o_c), 64'd0);
      run("R6 half 3", mk(2'd1, 5'd1, 1'b1, 1'b0, 5'd2, 1'b0, 4'd11), 64'd0, 64'd3);
      chk("R6 half pred", 64'(o_pred), 64'h15);

      // R8 pulse lasts one cycle
      @(negedge clk);
      chk("R8 one-cycle pulse", 64'(o_valid), 64'd0);

      // R1 non-matching word leaves outputs alone
      held = o_pred;
      @(negedge clk);
      in_valid = 1'b1;
      in_instr = mk(2'd0, 5'd1, 1'b1, 1'b1, 5'd2, 1'b1, 4'd3) & ~32'h0020_0000;
      a_d = 64'd0; b_d = 64'd1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1 miss valid", 64'(o_valid), 64'd0);
      chk("R1 miss pred held", 64'(o_pred), 64'(held));

      // Random mix
      for (int k = 0; k < 400; k++) begin
         ins = mk(2'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
                  5'($urandom), 1'($urandom), 4'($urandom));
         ra  = {$urandom, $urandom};
         case ($urandom % 4)
            0: rb = {$urandom, $urandom};
            1: rb = ra + 64'($signed(6'($urandom)));
            2: rb = ra + 64'($urandom % 40);
            default: begin ra = 64'($signed(8'($urandom))); rb = 64'($signed(8'($urandom))); end
         endcase
         run("R6 random", ins, ra, rb);
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule